// File: doc/BRIEF.md
# Cell Header Check Octet Generator and Checker

This block works out the 8-bit check octet that protects a fixed-length cell header. The header enters one octet per clock on a byte stream with a valid qualifier and a start marker on the first octet. Once the last covered header octet has been accepted, the block presents the octet that a transmitter places in the fifth header position. If the stream then carries a fifth octet, which is the check octet received with the cell, the block compares it against the value it computed. It reports a match flag and the syndrome, which is the XOR of the two.

The check is a CRC-8 with generator x^8 + x^2 + x + 1. The remainder starts at zero for each header, bits enter MSB first, and no final inversion is applied. A run-time select bit sets the coverage. With the bit low, all four header octets are covered. With it high, the first octet is skipped and only octets two to four are covered, which is the short-header variant. A second run-time bit XORs the coset pattern 0x55 (x^6 + x^4 + x^2 + 1) into the remainder. The same adjusted value is used both for the transmitted octet and for the receive comparison.

The configuration bits must stay steady across a header. The header length, the octet width, the generator and the coset pattern are parameters.

Top module: `hec_unit`

## Requirements
- R1: After reset, tx_hec_valid, rx_chk_valid and rx_match are 0, and tx_hec and rx_syndrome are 0x00.
- R2: With cfg_skip_first low and cfg_coset_en low, tx_hec equals the CRC-8 remainder of header octets 1 to 4. The generator is x^8+x^2+x+1, the initial value is 0, bits are taken MSB first and there is no final XOR. For the header 00 00 00 01 the result is 0x07.
- R3: With cfg_skip_first high, octet 1 has no effect on the result, and tx_hec is the remainder of octets 2 to 4 alone.
- R4: With cfg_coset_en high, tx_hec is the remainder XOR 0x55. For the header 00 00 00 01 this gives 0x52.
- R5: tx_hec_valid is high for exactly one cycle, in the cycle after octet 4 is accepted. tx_hec keeps its value until the next header's octet 4.
- R6: rx_chk_valid is high for one cycle, in the cycle after octet 5 is accepted. At that point rx_syndrome equals octet 5 XOR the expected check octet, coset included when enabled, and rx_match is 1 exactly when the syndrome is zero.
- R7: An octet with hdr_sop high is always taken as octet 1. A start marker in the middle of a header discards the partial remainder, and the new header's result depends only on its own octets.
- R8: Cycles with hdr_valid low are not counted, so gaps inside a header are allowed. Octets that arrive without a start marker after octet 5 produce no valid pulse and leave tx_hec unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_skip_first | input | 1 | 1: leave octet 1 out of coverage |
| cfg_coset_en | input | 1 | 1: XOR 0x55 into the computed value |
| hdr_valid | input | 1 | hdr_octet carries an octet this cycle |
| hdr_sop | input | 1 | Marks octet 1 of a header |
| hdr_octet | input | 8 | Header octet |
| tx_hec_valid | output | 1 | One-cycle pulse: tx_hec is fresh |
| tx_hec | output | 8 | Check octet to insert as octet 5 |
| rx_chk_valid | output | 1 | One-cycle pulse: check result is fresh |
| rx_match | output | 1 | Received octet 5 equals the expected value |
| rx_syndrome | output | 8 | Received octet 5 XOR the expected value |

## Verification
The main sweep runs under all four settings of the coverage and coset bits. In each header one octet position takes every value from 0 to 255 while the other positions hold fixed filler. This shows whether every covered octet reaches the remainder with the right weight, and whether octet 1 truly drops out in short-coverage mode. The received fifth octet is the expected value XORed with either zero or a single-bit error in any bit position. This separates a correct syndrome from a merely nonzero one. Directed headers add a known anchor value, gaps in hdr_valid, an aborted partial header and trailing octets that carry no start marker.

// File: rtl/hec_pkg.sv
package hec_pkg;

   // Per-octet control decoded by the sequencer
   typedef struct packed {
      logic start;     // octet is octet 1 of a header
      logic covered;   // octet enters the remainder
      logic tx_fire;   // octet is the last covered position
      logic rx_fire;   // octet is the received check octet
   } hec_ctl_t;

endpackage

// File: rtl/hec_octet_seq.sv
module hec_octet_seq
   import hec_pkg::*;
#(
   parameter int HDR_OCTETS     = 4,
   parameter bit SHORT_COVER_EN = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     skip_first,
   input  logic     in_valid,
   input  logic     in_sop,
   output hec_ctl_t ctl,
   output logic     accept
);
   localparam int POS_W = $clog2(HDR_OCTETS + 1);
   localparam logic [POS_W-1:0] LAST_COV = POS_W'(HDR_OCTETS - 1);
   localparam logic [POS_W-1:0] CHK_POS  = POS_W'(HDR_OCTETS);

   logic             active_q;
   logic [POS_W-1:0] next_pos_q;
   logic [POS_W-1:0] pos;
   logic             skip_eff;

   generate
      if (SHORT_COVER_EN) begin : g_short
         assign skip_eff = skip_first;
      end else begin : g_full
         assign skip_eff = 1'b0;
      end
   endgenerate

   assign accept = in_valid && (in_sop || active_q);
   assign pos    = in_sop ? '0 : next_pos_q;

   always_comb begin
      ctl.start   = accept && in_sop;
      ctl.covered = accept && (pos < CHK_POS) && !(skip_eff && pos == '0);
      ctl.tx_fire = accept && (pos == LAST_COV);
      ctl.rx_fire = accept && (pos == CHK_POS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         next_pos_q <= '0;
      end else if (accept) begin
         if (pos == CHK_POS) begin
            active_q   <= 1'b0;
            next_pos_q <= '0;
         end else begin
            active_q   <= 1'b1;
            next_pos_q <= pos + 1'b1;
         end
      end
   end

   // R7: a start marker always restarts at position 1
   a_r7_sop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop) |=> (active_q && next_pos_q == POS_W'(1)));
endmodule

// File: rtl/hec_crc_acc.sv
module hec_crc_acc
   import hec_pkg::*;
#(
   parameter int                OCTET_W  = 8,
   parameter logic [OCTET_W-1:0] GEN_POLY = 8'h07
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  hec_ctl_t           ctl,
   input  logic [OCTET_W-1:0] octet,
   output logic [OCTET_W-1:0] crc_now
);
   logic [OCTET_W-1:0] crc_q;
   logic [OCTET_W-1:0] base;

   function automatic logic [OCTET_W-1:0] step_octet(
      input logic [OCTET_W-1:0] c_in, input logic [OCTET_W-1:0] d);
      logic [OCTET_W-1:0] c;
      logic               fb;
      c = c_in;
      for (int i = OCTET_W - 1; i >= 0; i--) begin
         fb = c[OCTET_W-1] ^ d[i];
         c  = {c[OCTET_W-2:0], 1'b0} ^ (fb ? GEN_POLY : '0);
      end
      return c;
   endfunction

   assign base    = ctl.start ? '0 : crc_q;
   assign crc_now = ctl.covered ? step_octet(base, octet) : base;

   always_ff @(posedge clk) begin
      if (!rst_n)      crc_q <= '0;
      else if (accept) crc_q <= crc_now;
   end
endmodule

// File: rtl/hec_result.sv
module hec_result
   import hec_pkg::*;
#(
   parameter int                OCTET_W   = 8,
   parameter logic [OCTET_W-1:0] COSET_PAT = 8'h55
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               coset_en,
   input  hec_ctl_t           ctl,
   input  logic [OCTET_W-1:0] octet,
   input  logic [OCTET_W-1:0] crc_now,
   output logic               tx_valid,
   output logic [OCTET_W-1:0] tx_val,
   output logic               rx_valid,
   output logic               rx_ok,
   output logic [OCTET_W-1:0] rx_syn
);
   logic [OCTET_W-1:0] adjusted;

   generate
      if (COSET_PAT == '0) begin : g_no_coset
         assign adjusted = crc_now;
      end else begin : g_coset
         assign adjusted = crc_now ^ (coset_en ? COSET_PAT : '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_val   <= '0;
         rx_valid <= 1'b0;
         rx_ok    <= 1'b0;
         rx_syn   <= '0;
      end else begin
         tx_valid <= ctl.tx_fire;
         rx_valid <= ctl.rx_fire;
         if (ctl.tx_fire) tx_val <= adjusted;
         if (ctl.rx_fire) begin
            rx_syn <= octet ^ tx_val;
            rx_ok  <= (octet == tx_val);
         end
      end
   end

   // R5: transmit pulse lasts one cycle
   a_r5_tx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid);
   // R6: check result never coincides with a transmit result
   a_r6_tx_rx_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_valid && rx_valid));
   // R8: the transmitted value is not disturbed by the check octet
   a_r8_tx_held_at_check: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $stable(tx_val));
endmodule

// File: rtl/hec_unit.sv
module hec_unit #(
   parameter int   OCTET_W        = 8,
   parameter int   HDR_OCTETS     = 4,
   parameter logic [OCTET_W-1:0] GEN_POLY  = 8'h07,
   parameter logic [OCTET_W-1:0] COSET_PAT = 8'h55,
   parameter bit   SHORT_COVER_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_skip_first,
   input  logic               cfg_coset_en,
   input  logic               hdr_valid,
   input  logic               hdr_sop,
   input  logic [OCTET_W-1:0] hdr_octet,
   output logic               tx_hec_valid,
   output logic [OCTET_W-1:0] tx_hec,
   output logic               rx_chk_valid,
   output logic               rx_match,
   output logic [OCTET_W-1:0] rx_syndrome
);
   import hec_pkg::*;

   generate
      if (HDR_OCTETS < 2) begin : g_bad_len
         $error("hec_unit: HDR_OCTETS must be at least 2");
      end
      if (OCTET_W < 2) begin : g_bad_width
         $error("hec_unit: OCTET_W must be at least 2");
      end
   endgenerate

   hec_ctl_t ctl;
   logic     accept;
   logic [OCTET_W-1:0] crc_now;

   hec_octet_seq #(
      .HDR_OCTETS    (HDR_OCTETS),
      .SHORT_COVER_EN(SHORT_COVER_EN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .skip_first(cfg_skip_first),
      .in_valid  (hdr_valid),
      .in_sop    (hdr_sop),
      .ctl       (ctl),
      .accept    (accept)
   );

   hec_crc_acc #(
      .OCTET_W (OCTET_W),
      .GEN_POLY(GEN_POLY)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .ctl    (ctl),
      .octet  (hdr_octet),
      .crc_now(crc_now)
   );

   hec_result #(
      .OCTET_W  (OCTET_W),
      .COSET_PAT(COSET_PAT)
   ) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .coset_en(cfg_coset_en),
      .ctl     (ctl),
      .octet   (hdr_octet),
      .crc_now (crc_now),
      .tx_valid(tx_hec_valid),
      .tx_val  (tx_hec),
      .rx_valid(rx_chk_valid),
      .rx_ok   (rx_match),
      .rx_syn  (rx_syndrome)
   );

   // R5: a transmit result always follows an accepted octet
   a_r5_tx_after_octet: assert property (@(posedge clk) disable iff (!rst_n)
      tx_hec_valid |-> $past(hdr_valid));
   // R6: a check result always follows a non-start octet
   a_r6_rx_after_octet: assert property (@(posedge clk) disable iff (!rst_n)
      rx_chk_valid |-> $past(hdr_valid && !hdr_sop));
endmodule

// File: tb/hec_unit_test.sv
`timescale 1ns/1ps
module hec_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_skip_first = 1'b0;
   logic       cfg_coset_en = 1'b0;
   logic       hdr_valid = 1'b0;
   logic       hdr_sop = 1'b0;
   logic [7:0] hdr_octet = 8'h00;
   logic       tx_hec_valid, rx_chk_valid, rx_match;
   logic [7:0] tx_hec, rx_syndrome;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   hec_unit uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_skip_first(cfg_skip_first), .cfg_coset_en(cfg_coset_en),
      .hdr_valid(hdr_valid), .hdr_sop(hdr_sop), .hdr_octet(hdr_octet),
      .tx_hec_valid(tx_hec_valid), .tx_hec(tx_hec),
      .rx_chk_valid(rx_chk_valid), .rx_match(rx_match), .rx_syndrome(rx_syndrome)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Remainder by long division of the 32-bit header times x^8
   function automatic logic [7:0] ref_rem(input logic [31:0] msg);
      logic [39:0] r;
      r = {msg, 8'h00};
      for (int i = 39; i >= 8; i--)
         if (r[i]) r = r ^ (40'h107 << (i - 8));
      return r[7:0];
   endfunction

   function automatic logic [7:0] expect_hec(input logic [7:0] a, input logic [7:0] b,
                                             input logic [7:0] c, input logic [7:0] d);
      logic [31:0] m;
      m = {(cfg_skip_first ? 8'h00 : a), b, c, d};
      return ref_rem(m) ^ (cfg_coset_en ? 8'h55 : 8'h00);
   endfunction

   task automatic put(input bit v, input bit s, input logic [7:0] b);
      @(negedge clk);
      hdr_valid = v; hdr_sop = s; hdr_octet = b;
   endtask

   task automatic settle();
      @(posedge clk); #1;
   endtask

   task automatic run_hdr(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                          input logic [7:0] d, input logic [7:0] err, input bit gaps,
                          input string req);
      logic [7:0] e;
      e = expect_hec(a, b, c, d);
      put(1, 1, a); if (gaps) put(0, 0, 8'hEE);
      put(1, 0, b); if (gaps) put(0, 1, 8'hEE);
      put(1, 0, c); if (gaps) put(0, 0, 8'hEE);
      put(1, 0, d);
      settle();
      chk(tx_hec_valid == 1'b1, {req, "/R5 tx pulse"}, tx_hec_valid, 1);
      chk(tx_hec == e, {req, " tx_hec"}, tx_hec, e);
      if (gaps) put(0, 0, 8'hEE);
      put(1, 0, e ^ err);
      settle();
      chk(tx_hec_valid == 1'b0, "R5 pulse width", tx_hec_valid, 0);
      chk(rx_chk_valid == 1'b1, "R6 rx pulse", rx_chk_valid, 1);
      chk(rx_syndrome == err, "R6 syndrome", rx_syndrome, err);
      chk(rx_match == (err == 8'h00), "R6 match", rx_match, (err == 8'h00));
      put(0, 0, 8'h00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(tx_hec_valid == 0 && rx_chk_valid == 0 && rx_match == 0, "R1 flags", 
          {tx_hec_valid, rx_chk_valid, rx_match}, 0);
      chk(tx_hec == 8'h00 && rx_syndrome == 8'h00, "R1 values", {tx_hec, rx_syndrome}, 0);
      @(negedge clk); rst_n = 1'b1;

      // R2 / R4 anchor values for header 00 00 00 01
      run_hdr(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, "R2 anchor");
      chk(tx_hec == 8'h07, "R2 anchor value", tx_hec, 8'h07);
      cfg_coset_en = 1'b1;
      run_hdr(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, "R4 anchor");
      chk(tx_hec == 8'h52, "R4 anchor value", tx_hec, 8'h52);

      // R3: octet 1 has no effect in short coverage
      cfg_coset_en = 1'b0; cfg_skip_first = 1'b1;
      run_hdr(8'hFF, 8'h12, 8'h34, 8'h56, 8'h00, 1'b0, "R3 first ignored");
      chk(tx_hec == ref_rem({8'h00, 8'h12, 8'h34, 8'h56}), "R3 value", tx_hec,
          ref_rem({8'h00, 8'h12, 8'h34, 8'h56}));
      cfg_skip_first = 1'b0;

      // R7: aborted header then a fresh one
      put(1, 1, 8'h9A); put(1, 0, 8'hBC); put(1, 0, 8'hDE);
      run_hdr(8'h01, 8'h23, 8'h45, 8'h67, 8'h04, 1'b0, "R7 restart");

      // R8: gaps in valid, then trailing octets without a start marker
      run_hdr(8'hC3, 8'h3C, 8'h5A, 8'hA5, 8'h80, 1'b1, "R8 gaps");
      begin
         logic [7:0] held;
         held = tx_hec;
         for (int k = 0; k < 6; k++) begin
            put(1, 0, 8'hFF);
            settle();
            chk(tx_hec_valid == 0 && rx_chk_valid == 0, "R8 trailing no pulse",
                {tx_hec_valid, rx_chk_valid}, 0);
            chk(tx_hec == held, "R8 tx_hec kept", tx_hec, held);
         end
         put(0, 0, 8'h00);
      end

      // Sweep: every configuration, every position, every value
      for (int cfg = 0; cfg < 4; cfg++) begin
         cfg_skip_first = cfg[0];
         cfg_coset_en   = cfg[1];
         for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 256; v++) begin
               logic [7:0] o[4];
               logic [7:0] err;
               for (int q = 0; q < 4; q++) o[q] = 8'((q * 37) + cfg + 8'h11);
               o[p] = 8'(v);
               err = ((v % 9) == 8) ? 8'h00 : 8'(1 << (v % 9));
               run_hdr(o[0], o[1], o[2], o[3], err, 1'b0,
                       cfg[0] ? "R3 sweep" : (cfg[1] ? "R4 sweep" : "R2 sweep"));
            end
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule